// File: doc/BRIEF.md
# Frame List Schedule Walker

This block is the per-frame sequencer of a host-side bus controller. A built-in divider produces one frame tick per millisecond of system clock. On each tick while `run` is high, the walker advances an 11-bit frame number. It posts any interrupt causes collected during the previous frame. It then reads the frame list entry for the new frame and follows link pointers through queue heads and transfer descriptors in shared memory.

Each descriptor is read in full and handed to an external descriptor-status unit for one cycle. That unit returns an updated control word, a result code and interrupt causes. The walker writes the control word back only if it changed. When a queued descriptor succeeds, the walker advances the queue head's element pointer and follows the depth-first flag. A loop counter bounds the work done in one frame. Memory traffic uses a 32-bit word port with a valid/ready handshake and one request in flight.

States (enum `walk_state_e`):
- `ST_IDLE`: waits for a tick. On a tick with `run` low it stays and sets `halted`. With `run` high it goes to `ST_LIST`.
- `ST_LIST`: reads the frame list entry, then goes to `ST_LINK`.
- `ST_LINK`: a terminated link or an exhausted budget goes to `ST_DONE`. A queue-head link goes to `ST_QH_H`. Any other link goes to `ST_TD_RD`.
- `ST_QH_H` → `ST_QH_E`: reads the horizontal link, then the element link.
- `ST_QH_EVAL`: goes to `ST_LINK` (horizontal move or descent), to `ST_TD_RD`, or to `ST_DONE` when the budget is used up.
- `ST_TD_RD`: reads four words, then goes to `ST_TD_EXEC`.
- `ST_TD_EXEC`: the handoff cycle. It goes to `ST_TD_WB` if the control word changed, otherwise to `ST_NEXT`.
- `ST_NEXT`: goes to `ST_DONE` on abort. Otherwise it goes to `ST_LINK`, or to `ST_QH_WB` after a queued success.
- `ST_QH_WB`: updates the element link, then goes to `ST_QH_EVAL` (depth-first) or to `ST_LINK`.
- `ST_DONE`: latches the causes gathered this frame and returns to `ST_IDLE`.

Top module: `frame_walker`

## Requirements
- R1: A tick occurs every `TICK_DIV` cycles. On a tick in `ST_IDLE` with `run` high, `frame_num` increments by one modulo 2048 and `halted` clears.
- R2: The first access of each frame is a read at `fl_base + {frame_num[9:0], 2'b00}`. A value with bit 0 set read there ends the frame's walk with no further access.
- R3: In a link pointer, bit 0 means terminate, bit 1 means queue head (otherwise descriptor) and bit 2 means depth-first. The target address is the pointer with bits [3:0] cleared. A queue head is read as the horizontal link at +0, then the element link at +4.
- R4: If the element link has bit 0 set, the walk continues at the horizontal link. If it has bit 1 set, the walk descends into that queue head. Otherwise the descriptor at the element link is read as four words: link, control, token, buffer.
- R5: A queued descriptor with result 0 (success) makes the walker write the descriptor's link into queue head +4. If that link has bit 2 set, the next element is processed at once; otherwise the walk moves to the horizontal link. Any other result leaves +4 untouched and moves horizontally.
- R6: The returned control word is written to descriptor +4 only when it differs from the control word that was read.
- R7: Result 2 (abort) ends the frame's walk after any control write-back. Later links in that frame are not visited.
- R8: At most `LOOP_MAX` link and element visits are made per frame. A self-linked schedule still ends, and the next frame still runs.
- R9: Interrupt causes are ORed together over a frame. At the next running tick they appear on `irq_cause` with a one-cycle `irq_post` pulse. A frame with no causes gives no pulse.
- R10: After reset, or from the first tick with `run` low, `halted` is 1, `frame_num` is frozen and no memory request is made.
- R11: While `mem_req` is high without `mem_ready`, the request and its address hold.
- R12: `td_valid` is high for exactly one cycle per descriptor and presents that descriptor's control, token and buffer words. The result inputs are sampled in that cycle. Result codes: 0 success, 1 not done, 2 abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run (1) / stop (0) control |
| fl_base | input | 32 | Frame list base address |
| frame_num | output | 11 | Current frame number |
| halted | output | 1 | Walker stopped |
| irq_post | output | 1 | One-cycle pulse posting the previous frame's causes |
| irq_cause | output | 2 | Causes posted with `irq_post` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| td_valid | output | 1 | Descriptor handoff strobe |
| td_ctrl | output | 32 | Descriptor control word |
| td_token | output | 32 | Descriptor token word |
| td_buffer | output | 32 | Descriptor buffer pointer |
| td_res | input | 2 | Result code from the status unit |
| td_ctrl_new | input | 32 | Updated control word |
| td_ints | input | 2 | Interrupt causes raised by this descriptor |

## Verification
`frame_num` and `irq_post` change on the same edge as the tick. They are sampled on the falling edge right after the bench first sees the new frame number, and the gap between successive frame numbers is counted in exact cycles. Memory side effects of frame N are only settled by the next tick, so the bench checks them once frame N+1 has started. Accesses are counted at rising edges, so writes that must not happen and visits that must be capped are counted per address rather than timed. The stop test waits one full tick period plus two cycles before it checks `halted`.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int FRAME_BITS = 11;
    localparam int INDEX_BITS = 10;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_SKIP  = 2'd1;
    localparam logic [1:0] RES_ABORT = 2'd2;

    localparam int LNK_TERM  = 0;
    localparam int LNK_QH    = 1;
    localparam int LNK_DEPTH = 2;
    localparam logic [31:0] LNK_MASK = 32'hFFFF_FFF0;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LIST, ST_LINK, ST_QH_H, ST_QH_E, ST_QH_EVAL,
        ST_TD_RD, ST_TD_EXEC, ST_TD_WB, ST_NEXT, ST_QH_WB, ST_DONE
    } walk_state_e;
endpackage

// File: rtl/frame_ticker.sv
module frame_ticker #(
    parameter int TICK_DIV = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
    import walk_pkg::*;
#(
    parameter int LOOP_MAX = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  run,
    input  logic [31:0]           fl_base,
    output logic [FRAME_BITS-1:0] frame_num,
    output logic                  halted,
    output logic                  irq_post,
    output logic [1:0]            irq_cause,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [31:0]           mem_addr,
    output logic [31:0]           mem_wdata,
    input  logic                  mem_ready,
    input  logic [31:0]           mem_rdata,
    output logic                  td_valid,
    output logic [31:0]           td_ctrl,
    output logic [31:0]           td_token,
    output logic [31:0]           td_buffer,
    input  logic [1:0]            td_res,
    input  logic [31:0]           td_ctrl_new,
    input  logic [1:0]            td_ints
);
    localparam int VW = $clog2(LOOP_MAX + 1);
    localparam logic [VW-1:0] VMAX = VW'(LOOP_MAX);

    walk_state_e state, state_d;
    logic [31:0] link_q, qh_addr, qh_hlink, el_link, td_addr;
    logic [31:0] td_link, ctrl_q, token_q, buf_q, new_ctrl_q;
    logic [1:0]  wi, res_q, gathered, pending;
    logic        in_q;
    logic [VW-1:0] visits;

    // next-state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    if (tick && run) state_d = ST_LIST;
            ST_LIST:    if (mem_ready) state_d = ST_LINK;
            ST_LINK: begin
                if (link_q[LNK_TERM] || visits == VMAX) state_d = ST_DONE;
                else if (link_q[LNK_QH])                state_d = ST_QH_H;
                else                                    state_d = ST_TD_RD;
            end
            ST_QH_H:    if (mem_ready) state_d = ST_QH_E;
            ST_QH_E:    if (mem_ready) state_d = ST_QH_EVAL;
            ST_QH_EVAL: begin
                if (el_link[LNK_TERM] || el_link[LNK_QH]) state_d = ST_LINK;
                else if (visits == VMAX)                 state_d = ST_DONE;
                else                                     state_d = ST_TD_RD;
            end
            ST_TD_RD:   if (mem_ready && wi == 2'd3) state_d = ST_TD_EXEC;
            ST_TD_EXEC: state_d = (td_ctrl_new != ctrl_q) ? ST_TD_WB : ST_NEXT;
            ST_TD_WB:   if (mem_ready) state_d = ST_NEXT;
            ST_NEXT: begin
                if (res_q == RES_ABORT)   state_d = ST_DONE;
                else if (!in_q)           state_d = ST_LINK;
                else if (res_q == RES_OK) state_d = ST_QH_WB;
                else                      state_d = ST_LINK;
            end
            ST_QH_WB:   if (mem_ready) state_d = td_link[LNK_DEPTH] ? ST_QH_EVAL : ST_LINK;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_num <= '0;   halted   <= 1'b1;  irq_post <= 1'b0;  irq_cause <= '0;
            link_q    <= '0;   qh_addr  <= '0;    qh_hlink <= '0;    el_link   <= '0;
            td_addr   <= '0;   td_link  <= '0;    ctrl_q   <= '0;    token_q   <= '0;
            buf_q     <= '0;   new_ctrl_q <= '0;  wi       <= '0;    res_q     <= '0;
            gathered  <= '0;   pending  <= '0;    in_q     <= 1'b0;  visits    <= '0;
        end else begin
            irq_post <= 1'b0;
            unique case (state)
                ST_IDLE: if (tick) begin
                    if (run) begin
                        frame_num <= frame_num + FRAME_BITS'(1);
                        halted    <= 1'b0;
                        irq_post  <= |pending;
                        irq_cause <= pending;
                        pending   <= '0;
                        gathered  <= '0;
                        visits    <= '0;
                    end else begin
                        halted <= 1'b1;
                    end
                end
                ST_LIST: if (mem_ready) link_q <= mem_rdata;
                ST_LINK: if (!link_q[LNK_TERM] && visits != VMAX) begin
                    visits <= visits + VW'(1);
                    if (link_q[LNK_QH]) qh_addr <= link_q & LNK_MASK;
                    else begin
                        td_addr <= link_q & LNK_MASK;
                        in_q    <= 1'b0;
                        wi      <= '0;
                    end
                end
                ST_QH_H: if (mem_ready) qh_hlink <= mem_rdata;
                ST_QH_E: if (mem_ready) el_link  <= mem_rdata;
                ST_QH_EVAL: begin
                    if (el_link[LNK_TERM])     link_q <= qh_hlink;
                    else if (el_link[LNK_QH])  link_q <= el_link;
                    else if (visits != VMAX) begin
                        visits  <= visits + VW'(1);
                        td_addr <= el_link & LNK_MASK;
                        in_q    <= 1'b1;
                        wi      <= '0;
                    end
                end
                ST_TD_RD: if (mem_ready) begin
                    unique case (wi)
                        2'd0: td_link <= mem_rdata;
                        2'd1: ctrl_q  <= mem_rdata;
                        2'd2: token_q <= mem_rdata;
                        default: buf_q <= mem_rdata;
                    endcase
                    wi <= wi + 2'd1;
                end
                ST_TD_EXEC: begin
                    res_q      <= td_res;
                    new_ctrl_q <= td_ctrl_new;
                    gathered   <= gathered | td_ints;
                end
                ST_NEXT: begin
                    if (!in_q)                              link_q <= td_link;
                    else if (res_q != RES_OK)               link_q <= qh_hlink;
                end
                ST_QH_WB: if (mem_ready) begin
                    if (td_link[LNK_DEPTH]) el_link <= td_link;
                    else                    link_q  <= qh_hlink;
                end
                ST_DONE: pending <= gathered;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_LIST:  begin mem_req = 1'b1; mem_addr = fl_base + {20'd0, frame_num[INDEX_BITS-1:0], 2'b00}; end
            ST_QH_H:  begin mem_req = 1'b1; mem_addr = qh_addr; end
            ST_QH_E:  begin mem_req = 1'b1; mem_addr = qh_addr + 32'd4; end
            ST_TD_RD: begin mem_req = 1'b1; mem_addr = td_addr + {28'd0, wi, 2'b00}; end
            ST_TD_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = td_addr + 32'd4; mem_wdata = new_ctrl_q; end
            ST_QH_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = qh_addr + 32'd4; mem_wdata = td_link; end
            default: ;
        endcase
    end

    assign td_valid  = (state == ST_TD_EXEC);
    assign td_ctrl   = ctrl_q;
    assign td_token  = token_q;
    assign td_buffer = buf_q;
endmodule

// File: rtl/frame_walker.sv
module frame_walker #(
    parameter int TICK_DIV = 200000,
    parameter int LOOP_MAX = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [31:0] fl_base,
    output logic [10:0] frame_num,
    output logic        halted,
    output logic        irq_post,
    output logic [1:0]  irq_cause,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        td_valid,
    output logic [31:0] td_ctrl,
    output logic [31:0] td_token,
    output logic [31:0] td_buffer,
    input  logic [1:0]  td_res,
    input  logic [31:0] td_ctrl_new,
    input  logic [1:0]  td_ints
);
    logic tick;

    frame_ticker #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    walk_fsm #(.LOOP_MAX(LOOP_MAX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .fl_base(fl_base),
        .frame_num(frame_num), .halted(halted), .irq_post(irq_post), .irq_cause(irq_cause),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .td_valid(td_valid), .td_ctrl(td_ctrl), .td_token(td_token), .td_buffer(td_buffer),
        .td_res(td_res), .td_ctrl_new(td_ctrl_new), .td_ints(td_ints)
    );
endmodule

// File: rtl/walk_chk.sv
module walk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [10:0] frame_num,
    input logic        halted,
    input logic        irq_post,
    input logic [1:0]  irq_cause,
    input logic        mem_req,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic        td_valid
);
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num != $past(frame_num)) |-> (frame_num == $past(frame_num) + 11'd1)); // R1
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> $stable(frame_num)); // R10
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_post |=> !irq_post); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_post |-> (irq_cause != 2'b00)); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R11
    AST_TD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        td_valid |=> !td_valid); // R12
endmodule

bind frame_walker walk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_num(frame_num), .halted(halted),
    .irq_post(irq_post), .irq_cause(irq_cause), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .td_valid(td_valid)
);

// File: tb/frame_walker_tb.sv
`timescale 1ns/1ps
module frame_walker_tb;
    localparam int DIV  = 64;
    localparam int LMAX = 8;
    localparam logic [31:0] ACT = 32'h0080_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] fl_base = 32'h0000_8000;
    logic [10:0] frame_num;
    logic        halted, irq_post, mem_req, mem_we, mem_ready, td_valid;
    logic [1:0]  irq_cause, td_res, td_ints;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, td_ctrl, td_token, td_buffer, td_ctrl_new;

    logic [31:0] mem [0:16383];
    logic        slow = 1'b0;
    logic        rdy_en = 1'b1;
    logic [31:0] cap_buf = '0;
    int          wr_5104 = 0, wr_5004 = 0, rd_7000 = 0, req_cnt = 0;
    int          checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    frame_walker #(.TICK_DIV(DIV), .LOOP_MAX(LMAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .fl_base(fl_base),
        .frame_num(frame_num), .halted(halted), .irq_post(irq_post), .irq_cause(irq_cause),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .td_valid(td_valid), .td_ctrl(td_ctrl), .td_token(td_token), .td_buffer(td_buffer),
        .td_res(td_res), .td_ctrl_new(td_ctrl_new), .td_ints(td_ints)
    );

    // memory model
    assign mem_ready = mem_req && rdy_en;
    assign mem_rdata = mem[mem_addr[15:2]];
    always @(negedge clk) rdy_en <= slow ? ~rdy_en : 1'b1;

    // descriptor-status model: token[1:0] result, [3:2] causes, [4] clear active, [5] capture
    assign td_res      = td_token[1:0];
    assign td_ints     = td_token[3:2];
    assign td_ctrl_new = td_token[4] ? (td_ctrl & ~ACT) : td_ctrl;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (mem_req) req_cnt++;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[15:2]] <= mem_wdata;
                if (mem_addr == 32'h5104) wr_5104++;
                if (mem_addr == 32'h5004) wr_5004++;
            end else begin
                if (mem_addr == 32'h7000) rd_7000++;
                if (mem_addr >= 32'h8000 && mem_addr < 32'h9000)  // R2 list address
                    chk(mem_addr == fl_base + {19'd0, frame_num[9:0], 2'b00}, "R2 list addr",
                        mem_addr, fl_base + {19'd0, frame_num[9:0], 2'b00});
            end
        end
        if (td_valid && td_token[5]) cap_buf <= td_buffer;
    end

    task automatic put_td(input int a, input logic [31:0] l, c, t, b);
        mem[a/4] = l; mem[a/4+1] = c; mem[a/4+2] = t; mem[a/4+3] = b;
    endtask
    task automatic put_qh(input int a, input logic [31:0] h, e);
        mem[a/4] = h; mem[a/4+1] = e;
    endtask
    task automatic entry(input int f, input logic [31:0] v);
        mem[(32'h8000 + f*4)/4] = v;
    endtask
    task automatic wait_frame(input int n);
        while (frame_num != 11'(n)) @(negedge clk);
    endtask

    task automatic build;
        for (int i = 0; i < 16384; i++) mem[i] = 32'h1;
        entry(1, 32'h2000); put_td(32'h2000, 1, ACT, 32'h34, 32'hCAFE_0001);
        entry(2, 32'h3002); put_qh(32'h3000, 1, 32'h3100);
        put_td(32'h3100, 32'h3204, ACT, 32'h10, 0); put_td(32'h3200, 1, ACT, 32'h18, 0);
        entry(3, 32'h4002); put_qh(32'h4000, 32'h4300, 32'h4100);
        put_td(32'h4100, 32'h4200, ACT, 32'h10, 0); put_td(32'h4200, 1, ACT, 32'h10, 0);
        put_td(32'h4300, 1, ACT, 32'h10, 0);
        entry(4, 32'h5002); put_qh(32'h5000, 1, 32'h5100); put_td(32'h5100, 1, ACT, 32'h01, 0);
        entry(5, 32'h6000); put_td(32'h6000, 32'h6100, ACT, 32'h12, 0);
        put_td(32'h6100, 1, ACT, 32'h10, 0);
        entry(6, 32'h7002); put_qh(32'h7000, 32'h7002, 1);
        entry(7, 32'h7802); put_qh(32'h7800, 1, 32'h7902); put_qh(32'h7900, 1, 32'h7A00);
        put_td(32'h7A00, 1, ACT, 32'h10, 0);
    endtask

    task automatic t_reset;
        chk(halted == 1'b1, "R10 reset halted", 32'(halted), 1);
        chk(frame_num == 0, "R10 reset frame", 32'(frame_num), 0);
        chk(mem_req == 1'b0 && irq_post == 1'b0, "R10 reset idle", 32'({mem_req, irq_post}), 0);
    endtask

    task automatic t_stopped;
        req_cnt = 0;
        repeat (3*DIV) @(negedge clk);
        chk(frame_num == 0, "R10 stopped frame", 32'(frame_num), 0);
        chk(req_cnt == 0, "R10 stopped no access", req_cnt, 0);
    endtask

    task automatic t_first_frames;
        int n;
        slow = 1'b1;
        run = 1'b1;
        wait_frame(1);
        chk(halted == 1'b0, "R1 running", 32'(halted), 0);
        n = 0;
        while (frame_num == 11'd1) begin @(negedge clk); n++; end
        chk(n == DIV, "R1 tick period", n, DIV);
        chk(irq_post && irq_cause == 2'b01, "R9 post frame1", 32'({irq_post, irq_cause}), 32'b101);
        chk(mem[32'h2004/4] == 0, "R3 R6 frame TD ctrl", mem[32'h2004/4], 0);
        chk(cap_buf == 32'hCAFE_0001, "R12 handoff buffer", cap_buf, 32'hCAFE_0001);
    endtask

    task automatic t_depth_first;
        wait_frame(3);
        chk(mem[32'h3104/4] == 0 && mem[32'h3204/4] == 0, "R5 depth chain done",
            mem[32'h3204/4], 0);
        chk(mem[32'h3004/4] == 1, "R5 element advanced to end", mem[32'h3004/4], 1);
        chk(irq_post && irq_cause == 2'b10, "R9 post frame2", 32'({irq_post, irq_cause}), 32'b110);
    endtask

    task automatic t_horizontal;
        wait_frame(4);
        slow = 1'b0;
        chk(mem[32'h4004/4] == 32'h4200, "R5 element advanced", mem[32'h4004/4], 32'h4200);
        chk(mem[32'h4204/4] == ACT, "R5 no depth step", mem[32'h4204/4], ACT);
        chk(mem[32'h4304/4] == 0, "R5 horizontal taken", mem[32'h4304/4], 0);
        chk(irq_post == 1'b0, "R9 no causes no pulse", 32'(irq_post), 0);
    endtask

    task automatic t_not_done;
        wait_frame(5);
        chk(wr_5104 == 0, "R6 unchanged ctrl not written", wr_5104, 0);
        chk(wr_5004 == 0 && mem[32'h5004/4] == 32'h5100, "R5 element kept", mem[32'h5004/4], 32'h5100);
    endtask

    task automatic t_abort;
        wait_frame(6);
        chk(mem[32'h6004/4] == 0, "R7 R6 abort ctrl written", mem[32'h6004/4], 0);
        chk(mem[32'h6104/4] == ACT, "R7 walk stopped", mem[32'h6104/4], ACT);
    endtask

    task automatic t_loop;
        wait_frame(7);
        chk(rd_7000 == LMAX, "R8 visit cap", rd_7000, LMAX);
        chk(frame_num == 7, "R8 next frame runs", 32'(frame_num), 7);
    endtask

    task automatic t_nested;
        wait_frame(8);
        chk(mem[32'h7A04/4] == 0, "R4 descended TD done", mem[32'h7A04/4], 0);
        chk(mem[32'h7904/4] == 1, "R4 inner element advanced", mem[32'h7904/4], 1);
        chk(mem[32'h7804/4] == 32'h7902, "R4 outer element kept", mem[32'h7804/4], 32'h7902);
    endtask

    task automatic t_wrap;
        wait_frame(2047);
        while (frame_num == 11'd2047) @(negedge clk);
        chk(frame_num == 0, "R1 wrap", 32'(frame_num), 0);
    endtask

    task automatic t_stop;
        logic [10:0] f;
        run = 1'b0;
        repeat (DIV + 2) @(negedge clk);
        chk(halted == 1'b1, "R10 halted after stop", 32'(halted), 1);
        f = frame_num;
        req_cnt = 0;
        repeat (2*DIV) @(negedge clk);
        chk(frame_num == f, "R10 frame frozen", 32'(frame_num), 32'(f));
        chk(req_cnt == 0, "R10 no access when halted", req_cnt, 0);
    endtask

    initial begin
        build();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_first_frames();
        t_depth_first();
        t_horizontal();
        t_not_done();
        t_abort();
        t_loop();
        t_nested();
        t_wrap();
        t_stop();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule